// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block counts video lines and raises an interrupt after a programmable number of them. A host processor programs it through single-cycle register writes in the upper part of its address space. The region selected by address bits [15:13] = 3'b110 holds the count controls, and the region with [15:13] = 3'b111 holds the interrupt controls. Address bit 0 picks which of the two controls in a region is hit. The video timing logic supplies `line_tick`, already qualified to one pulse per visible line.

On each tick the 8-bit counter either reloads from a latch or steps down by one. It reloads when it already holds zero or when software has asked for a reload. Only the step that brings the counter down to zero can raise the interrupt. The interrupt is a pending level that stays high until software disables the interrupt or the block is reset.

Top module: `scanline_irq_counter`

## Requirements
- R1: Reset clears the counter, the latch, the reload request, the enable and the pending level. After reset, ticks alone never raise `irq_pending`, because the latch holds zero.
- R2: A write with `wr_addr[15:13]`=3'b110 and `wr_addr[0]`=0 stores `wr_data` into the latch.
- R3: A write with `wr_addr[15:13]`=3'b110 and `wr_addr[0]`=1 clears the counter and sets the reload request.
- R4: A write with `wr_addr[15:13]`=3'b111 and `wr_addr[0]`=1 enables the interrupt.
- R5: A write with `wr_addr[15:13]`=3'b111 and `wr_addr[0]`=0 disables the interrupt and drops `irq_pending` on the next cycle.
- R6: On a tick, if the counter is zero or a reload is requested, the counter loads the latch, the request clears, and `irq_pending` is not raised. With a latch of zero, the interrupt therefore never fires.
- R7: On any other tick the counter decrements. If it reaches zero while the interrupt is enabled, `irq_pending` rises in the next cycle. After a reload request with latch value N≥1, this happens on tick N+1.
- R8: `irq_pending` stays high through further ticks until a disable write or reset clears it.
- R9: Writes whose `wr_addr[15:13]` is neither 3'b110 nor 3'b111, and cycles with `wr_en` low, change no state.
- R10: When a write and a tick fall in the same cycle, the write decides the fields it touches. A reload write discards that tick entirely. A disable write keeps `irq_pending` low. A latch write lets the tick load the latch value held before the write.
- R11: A decrement to zero while the interrupt is disabled sets nothing, and a later enable does not raise `irq_pending` for that earlier event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 16 | Write address; bits [15:13] select the region, bit 0 selects the control within it |
| wr_data | input | 8 | Write data; only the latch write uses it |
| line_tick | input | 1 | One-cycle pulse per visible video line |
| irq_pending | output | 1 | Interrupt pending level |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and latch, and a 16-bit address with a 3-bit region field. It uses latch values of 0 to 3, which brings the zero crossing, the zero-latch lockout, and the reload and wrap-around paths within a handful of ticks. The coincident write-and-tick cases run at those same small counts, so each priority rule shows up as an interrupt that either appears or stays away. The full 255-line count range is not swept.

// File: rtl/scanirq_pkg.sv
`timescale 1ns/1ps
package scanirq_pkg;

    // Decoded register strobes, at most one high per cycle.
    typedef struct packed {
        logic latch_wr;
        logic reload_wr;
        logic irq_on;
        logic irq_off;
    } scanirq_cmd_t;

endpackage

// File: rtl/scanirq_decode.sv
`timescale 1ns/1ps
module scanirq_decode
    import scanirq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int GROUP_W = 3,
    parameter logic [GROUP_W-1:0] CNT_GROUP = 3'b110,
    parameter logic [GROUP_W-1:0] IRQ_GROUP = 3'b111
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output scanirq_cmd_t      cmd
);
    localparam int GRP_LSB = ADDR_W - GROUP_W;

    logic [GROUP_W-1:0] group;
    logic               odd;
    logic               hit_cnt;
    logic               hit_irq;
    logic               unused_mid_bits;

    assign group           = wr_addr[ADDR_W-1:GRP_LSB];
    assign odd             = wr_addr[0];
    assign unused_mid_bits = ^wr_addr[GRP_LSB-1:1];
    assign hit_cnt         = wr_en && (group == CNT_GROUP);
    assign hit_irq         = wr_en && (group == IRQ_GROUP);

    always_comb begin
        cmd           = '0;
        cmd.latch_wr  = hit_cnt && !odd;
        cmd.reload_wr = hit_cnt &&  odd;
        cmd.irq_off   = hit_irq && !odd;
        cmd.irq_on    = hit_irq &&  odd;
    end
endmodule

// File: rtl/scanirq_core.sv
`timescale 1ns/1ps
module scanirq_core
    import scanirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  scanirq_cmd_t     cmd,
    input  logic [CNT_W-1:0] wr_data,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] latch;
        logic             reload;
        logic             en;
        logic             pend;
    } core_state_t;

    core_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        // counting step
        if (tick) begin
            if (st_q.cnt == CNT_ZERO || st_q.reload) begin
                st_d.cnt    = st_q.latch;
                st_d.reload = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_ONE;
                if (st_q.cnt == CNT_ONE && st_q.en) begin
                    st_d.pend = 1'b1;
                end
            end
        end
        // register writes override the fields they touch
        if (cmd.latch_wr) begin
            st_d.latch = wr_data;
        end
        if (cmd.reload_wr) begin
            st_d.cnt    = CNT_ZERO;
            st_d.reload = 1'b1;
            st_d.pend   = st_q.pend;
        end
        if (cmd.irq_on) begin
            st_d.en = 1'b1;
        end
        if (cmd.irq_off) begin
            st_d.en   = 1'b0;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.pend;

    assert_latch_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.latch_wr |=> st_q.latch == $past(wr_data));

    assert_reload_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.reload_wr |=> (st_q.cnt == CNT_ZERO) && st_q.reload);

    assert_enable_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.irq_on |=> st_q.en);

    assert_disable_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.irq_off |=> !st_q.en && !st_q.pend);

    assert_zero_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cmd.reload_wr && (st_q.cnt == CNT_ZERO || st_q.reload))
        |=> (st_q.cnt == $past(st_q.latch)) && !st_q.reload);

    assert_fire_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(tick && !cmd.reload_wr && !cmd.irq_off
                                   && !st_q.reload && st_q.en && st_q.cnt == CNT_ONE));

    assert_pending_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !cmd.irq_off) |=> st_q.pend);

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cmd.irq_off) |=> !st_q.pend);
endmodule

// File: rtl/scanline_irq_counter.sv
`timescale 1ns/1ps
module scanline_irq_counter
    import scanirq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              line_tick,
    output logic              irq_pending
);
    scanirq_cmd_t cmd;

    scanirq_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .cmd     (cmd)
    );

    scanirq_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (line_tick),
        .cmd     (cmd),
        .wr_data (wr_data),
        .irq     (irq_pending)
    );

    assert_quiet_decode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (cmd == '0));

    assert_single_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd));
endmodule

// File: tb/scanline_irq_counter_tb.sv
`timescale 1ns/1ps
module scanline_irq_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_tick = 1'b0;
    logic        irq_pending;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    scanline_irq_counter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .line_tick   (line_tick),
        .irq_pending (irq_pending)
    );

    // {op[1:0], addr[15:0], data[7:0], expected irq}; op 0=write 1=tick 2=idle
    localparam int NV = 27;
    localparam logic [26:0] VEC [0:NV-1] = '{
        {2'd0, 16'hC000, 8'h03, 1'b0},
        {2'd0, 16'hE001, 8'h00, 1'b0},
        {2'd0, 16'hC001, 8'h00, 1'b0},
        {2'd1, 16'h0000, 8'h00, 1'b0},
        {2'd1, 16'h0000, 8'h00, 1'b0},
        {2'd1, 16'h0000, 8'h00, 1'b0},
        {2'd1, 16'h0000, 8'h00, 1'b1},
        {2'd1, 16'h0000, 8'h00, 1'b1},
        {2'd2, 16'h0000, 8'h00, 1'b1},
        {2'd0, 16'h8000, 8'hFF, 1'b1},
        {2'd0, 16'hE000, 8'h00, 1'b0},
        {2'd1, 16'h0000, 8'h00, 1'b0},
        {2'd1, 16'h0000, 8'h00, 1'b0},
        {2'd1, 16'h0000, 8'h00, 1'b0},
        {2'd0, 16'hE001, 8'h00, 1'b0},
        {2'd1, 16'h0000, 8'h00, 1'b0},
        {2'd0, 16'hC000, 8'h01, 1'b0},
        {2'd1, 16'h0000, 8'h00, 1'b0},
        {2'd1, 16'h0000, 8'h00, 1'b0},
        {2'd1, 16'h0000, 8'h00, 1'b1},
        {2'd0, 16'hE000, 8'h00, 1'b0},
        {2'd0, 16'hC000, 8'h00, 1'b0},
        {2'd0, 16'hC001, 8'h00, 1'b0},
        {2'd0, 16'hE001, 8'h00, 1'b0},
        {2'd1, 16'h0000, 8'h00, 1'b0},
        {2'd1, 16'h0000, 8'h00, 1'b0},
        {2'd1, 16'h0000, 8'h00, 1'b0}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:       return "R2";
            1, 14:   return "R4";
            2:       return "R3";
            3, 15:   return "R6";
            6, 19:   return "R7";
            7, 8:    return "R8";
            9:       return "R9";
            10, 20:  return "R5";
            13:      return "R11";
            24, 25, 26: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: irq_pending=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic do_wr, input logic [15:0] a,
                       input logic [7:0] d, input logic do_tick);
        @(negedge clk);
        wr_en     = do_wr;
        wr_addr   = a;
        wr_data   = d;
        line_tick = do_tick;
        @(posedge clk);
        #1;
        wr_en     = 1'b0;
        line_tick = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic tk();
        cyc(1'b0, 16'h0000, 8'h00, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        chk(irq_pending, 1'b0, "R1 reset state");

        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            v = VEC[i];
            case (v[26:25])
                2'd0:    cyc(1'b1, v[24:9], v[8:1], 1'b0);
                2'd1:    cyc(1'b0, 16'h0000, 8'h00, 1'b1);
                default: cyc(1'b0, 16'h0000, 8'h00, 1'b0);
            endcase
            chk(irq_pending, v[0], vec_tag(i));
        end

        // R1: reset clears a pending interrupt, the enable and the latch
        do_reset();
        wr(16'hC000, 8'h01); wr(16'hC001, 8'h00); wr(16'hE001, 8'h00);
        tk(); tk();
        chk(irq_pending, 1'b1, "R7 before reset");
        do_reset();
        #1;
        chk(irq_pending, 1'b0, "R1 pending cleared");
        wr(16'hC000, 8'h01); wr(16'hC001, 8'h00);
        tk(); tk();
        chk(irq_pending, 1'b0, "R1 enable cleared");
        do_reset();
        wr(16'hE001, 8'h00);
        tk(); tk(); tk();
        chk(irq_pending, 1'b0, "R1 latch cleared");

        // R9: other regions and idle strobes leave the latch alone
        do_reset();
        wr(16'hC000, 8'h01); wr(16'hC001, 8'h00); wr(16'hE001, 8'h00);
        wr(16'hA000, 8'h05); wr(16'h6000, 8'h05);
        cyc(1'b0, 16'hC000, 8'h05, 1'b0);
        tk(); tk();
        chk(irq_pending, 1'b1, "R9 latch untouched");

        // R10: reload write in the same cycle as a decrement to zero
        do_reset();
        wr(16'hC000, 8'h02); wr(16'hC001, 8'h00); wr(16'hE001, 8'h00);
        tk(); tk();
        cyc(1'b1, 16'hC001, 8'h00, 1'b1);
        chk(irq_pending, 1'b0, "R10 reload beats tick");
        tk(); tk();
        chk(irq_pending, 1'b0, "R10 recount");
        tk();
        chk(irq_pending, 1'b1, "R10 fires after reload");

        // R10: disable write in the same cycle as a decrement to zero
        do_reset();
        wr(16'hC000, 8'h01); wr(16'hC001, 8'h00); wr(16'hE001, 8'h00);
        tk();
        cyc(1'b1, 16'hE000, 8'h00, 1'b1);
        chk(irq_pending, 1'b0, "R10 disable beats tick");
        tk(); tk();
        chk(irq_pending, 1'b0, "R5 stays disabled");

        // R10: latch write with a loading tick uses the old latch
        do_reset();
        wr(16'hC000, 8'h01); wr(16'hC001, 8'h00); wr(16'hE001, 8'h00);
        cyc(1'b1, 16'hC000, 8'h05, 1'b1);
        chk(irq_pending, 1'b0, "R10 load cycle");
        tk();
        chk(irq_pending, 1'b1, "R10 old latch loaded");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule